// File: doc/BRIEF.md
# Threshold-Gated Longword Byte Transmitter

This block moves 16-bit samples out of an upstream first-in first-out buffer and onto a byte-wide link that uses an active-low strobe from the sender and an active-low ready from the receiver. Two consecutive samples are gathered into one 32-bit longword. The longword is then sent as four bytes, one handshake per byte. The older sample fills the low half of the longword, and each sample goes out low byte first.

Transfers are gated by the buffer's half-full flag. The controller stays quiet while the buffer is below that level. Each time it finds the flag raised and the buffer not empty, it reads two samples into a holding register and sends exactly one longword. It then looks at the flag again. A buffer that stays at or above the level therefore drains back to back for as long as the receiver keeps answering. A longword that has begun always runs to its fourth byte, whatever the flags do meanwhile. The ready input is resynchronised before the controller uses it.

The block only ever transmits and has no direction or token inputs. Two outputs exist for observation: a busy flag and a count of finished longwords.

Top module: `strobe_word_tx`

## Requirements
- R1: The byte order on `txData` follows the order in which samples were written to the buffer. For each pair of samples A (older) and B: A[7:0], A[15:8], B[7:0], B[15:8].
- R2: While `fifoHalf` is low and the block is idle, it neither asserts `fifoRd` nor drives `txStrobeN` low.
- R3: Each time the idle controller finds `fifoHalf` high, it reads exactly two samples and sends exactly one longword, then evaluates the flag again. Starting from S buffered samples with a threshold T (S >= T), the number of longwords sent is (S-T)/2 rounded down, plus one.
- R4: While the buffer level stays at or above the threshold, longwords follow one another with no extra condition beyond the receiver's handshakes.
- R5: No longword begins while `fifoEmpty` is high, even if `fifoHalf` is also high.
- R6: Once the first read of a longword is issued, all four bytes are sent, even if `fifoHalf` falls or the receiver stalls in between.
- R7: `txStrobeN` falls only while ready is deasserted. It stays low, with `txData` unchanged, until the synchronised ready is seen. It then rises, and the next byte waits until ready has been released.
- R8: An active-low asynchronous `rstN` forces `txStrobeN` high, `fifoRd` low, `busy` low and `wordCount` to zero. After reset, nothing is sent until the buffer reaches the threshold.
- R9: `fifoRd` is high for exactly two cycles per longword.
- R10: `busy` is high from the first read of a longword until its last byte is released. `wordCount` increases by exactly one per completed longword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoData | input | 16 | Head word of the upstream buffer (show-ahead) |
| fifoEmpty | input | 1 | Upstream buffer holds no words |
| fifoHalf | input | 1 | Upstream buffer is at or above its half-full level |
| fifoRd | output | 1 | Pops the head word at the next clock edge |
| txData | output | 8 | Byte presented to the receiver |
| txStrobeN | output | 1 | Active-low strobe: the byte on `txData` is valid |
| txReadyN | input | 1 | Active-low ready from the receiver (asynchronous) |
| busy | output | 1 | A longword is in progress |
| wordCount | output | 16 | Count of completed longwords (wraps) |

## Verification
The assertions assume three things about the upstream buffer. It is show-ahead. A raised half-full flag means at least two words are present. The flags reflect a pop before the cycle after it. They also assume a receiver that asserts ready only while the strobe is low and that releases it before the next strobe. The bench buffer model pops one cycle after each read it sees and derives both flags from its own occupancy. The modelled receiver answers only a low strobe and releases ready only after the strobe rises. The single departure is the empty-buffer case, where half-full is forced high against an empty buffer. That case still respects the assertions, because no read may follow.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;

  // Controller phases: idle, fetching samples, strobe low, strobe released
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOAD    = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RELEASE = 2'd3
  } txState_e;

  // Strobes from the controller into the datapath
  typedef struct packed {
    logic load;      // capture fifoData into the next holding slot
    logic advance;   // move to the next byte lane
    logic wordDone;  // the last lane of a longword has been released
  } dpCtrl_t;

endpackage

// File: rtl/stx_ready_sync.sv
`timescale 1ns/1ps
module stx_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic readyN,
  output logic readySeen
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= 1'b1;
        else       chain[0] <= readyN;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= 1'b1;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign readySeen = ~chain[STAGES-1];

endmodule

// File: rtl/stx_ctrl.sv
`timescale 1ns/1ps
module stx_ctrl
  import stx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fifoEmpty,
  input  logic    fifoHalf,
  input  logic    readySeen,
  input  logic    loadLast,
  input  logic    lastByte,
  output logic    fifoRd,
  output logic    strobeN,
  output logic    busy,
  output dpCtrl_t ctl
);

  txState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        if (fifoHalf && !fifoEmpty) nextState = ST_LOAD;
      end
      ST_LOAD: begin
        ctl.load = 1'b1;
        if (loadLast) nextState = ST_STROBE;
      end
      ST_STROBE: begin
        if (readySeen) nextState = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (!readySeen) begin
          ctl.advance  = 1'b1;
          ctl.wordDone = lastByte;
          nextState    = lastByte ? ST_IDLE : ST_STROBE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign fifoRd  = (state == ST_LOAD);
  assign strobeN = (state != ST_STROBE);
  assign busy    = (state != ST_IDLE);

  // R5: a pop is never requested from an empty buffer
  assert_no_read_when_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> !fifoEmpty);

  // R2: idle and below threshold means no read in the following cycle
  assert_no_start_below_half_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !fifoHalf) |=> !fifoRd);

  // R7: the strobe holds low until the synchronised ready arrives
  assert_strobe_waits_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeN && !readySeen) |=> !strobeN);

  // R7: a new strobe starts only with ready released
  assert_strobe_start_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeN) |-> !readySeen);

endmodule

// File: rtl/stx_datapath.sv
`timescale 1ns/1ps
module stx_datapath
  import stx_pkg::*;
#(
  parameter int SAMPLE_W         = 16,
  parameter int BYTE_W           = 8,
  parameter int SAMPLES_PER_WORD = 2,
  parameter int COUNT_W          = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] fifoData,
  input  dpCtrl_t             ctl,
  output logic [BYTE_W-1:0]   byteOut,
  output logic                loadLast,
  output logic                lastByte,
  output logic [COUNT_W-1:0]  wordCount
);

  localparam int WORD_W = SAMPLE_W * SAMPLES_PER_WORD;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int BIDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LIDX_W = (SAMPLES_PER_WORD > 1) ? $clog2(SAMPLES_PER_WORD) : 1;

  logic [WORD_W-1:0] holdWord;
  logic [BIDX_W-1:0] byteIdx;
  logic [LIDX_W-1:0] loadIdx;
  logic [BYTE_W-1:0] byteLane [LANES];

  // Holding register: older sample lands in the lower slot
  always_ff @(posedge clk) begin
    for (int s = 0; s < SAMPLES_PER_WORD; s++) begin
      if (ctl.load && (loadIdx == LIDX_W'(s)))
        holdWord[s*SAMPLE_W +: SAMPLE_W] <= fifoData;
    end
  end

  assign loadLast = (loadIdx == LIDX_W'(SAMPLES_PER_WORD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         loadIdx <= '0;
    else if (ctl.load) loadIdx <= loadLast ? '0 : loadIdx + LIDX_W'(1);
  end

  // Byte lanes, lowest lane first on the wire
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign byteLane[g] = holdWord[g*BYTE_W +: BYTE_W];
  end

  assign lastByte = (byteIdx == BIDX_W'(LANES - 1));
  assign byteOut  = byteLane[byteIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            byteIdx <= '0;
    else if (ctl.advance) byteIdx <= lastByte ? '0 : byteIdx + BIDX_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wordCount <= '0;
    else if (ctl.wordDone) wordCount <= wordCount + COUNT_W'(1);
  end

  // R10: the longword count only ever steps by one
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordCount) |-> (wordCount == $past(wordCount) + COUNT_W'(1)));

endmodule

// File: rtl/strobe_word_tx.sv
`timescale 1ns/1ps
module strobe_word_tx
  import stx_pkg::*;
#(
  parameter int SAMPLE_W         = 16,
  parameter int BYTE_W           = 8,
  parameter int SAMPLES_PER_WORD = 2,
  parameter int SYNC_STAGES      = 2,
  parameter int COUNT_W          = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] fifoData,
  input  logic                fifoEmpty,
  input  logic                fifoHalf,
  output logic                fifoRd,
  output logic [BYTE_W-1:0]   txData,
  output logic                txStrobeN,
  input  logic                txReadyN,
  output logic                busy,
  output logic [COUNT_W-1:0]  wordCount
);

  dpCtrl_t ctl;
  logic    readySeen;
  logic    loadLast;
  logic    lastByte;

  stx_ready_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk       (clk),
    .rstN      (rstN),
    .readyN    (txReadyN),
    .readySeen (readySeen)
  );

  stx_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .fifoEmpty (fifoEmpty),
    .fifoHalf  (fifoHalf),
    .readySeen (readySeen),
    .loadLast  (loadLast),
    .lastByte  (lastByte),
    .fifoRd    (fifoRd),
    .strobeN   (txStrobeN),
    .busy      (busy),
    .ctl       (ctl)
  );

  stx_datapath #(
    .SAMPLE_W         (SAMPLE_W),
    .BYTE_W           (BYTE_W),
    .SAMPLES_PER_WORD (SAMPLES_PER_WORD),
    .COUNT_W          (COUNT_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .fifoData  (fifoData),
    .ctl       (ctl),
    .byteOut   (txData),
    .loadLast  (loadLast),
    .lastByte  (lastByte),
    .wordCount (wordCount)
  );

  // R7: the byte stays put for as long as the strobe stays low
  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!txStrobeN && !$past(txStrobeN)) |-> $stable(txData));

  // R6: a strobe is never issued while idle
  assert_strobe_only_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txStrobeN |-> busy);

endmodule

// File: tb/sim_strobe_word_tx.sv
`timescale 1ns/1ps
module sim_strobe_word_tx;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] fifoData = '0;
  logic        fifoEmpty = 1'b1;
  logic        fifoHalf = 1'b0;
  logic        txReadyN = 1'b1;
  logic        fifoRd;
  logic [7:0]  txData;
  logic        txStrobeN;
  logic        busy;
  logic [15:0] wordCount;

  always #10 clk = ~clk;

  strobe_word_tx u0 (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoHalf(fifoHalf), .fifoRd(fifoRd), .txData(txData),
    .txStrobeN(txStrobeN), .txReadyN(txReadyN), .busy(busy),
    .wordCount(wordCount)
  );

  logic [15:0] fifoQ[$];
  logic [7:0]  expQ[$];
  int checks = 0, fails = 0;
  int sampleSeq = 0;
  int rxDelay = 1, rxLimit = -1, rxWait = 0;
  int accepted = 0, rdCycles = 0;
  bit rdPrev = 0, forceHalf = 0, expectIdle = 0;
  string idleReq = "R2";
  bit prevStrobeN = 1;
  logic [7:0] prevData = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void driveFifo();
    fifoEmpty = (fifoQ.size() == 0);
    fifoHalf  = forceHalf || (fifoQ.size() >= HALF);
    fifoData  = (fifoQ.size() > 0) ? fifoQ[0] : 16'h0;
  endfunction

  task automatic pushSamples(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] s;
      s = 16'((sampleSeq * 40503 + 291) & 32'hFFFF);
      sampleSeq++;
      fifoQ.push_back(s);
      expQ.push_back(s[7:0]);
      expQ.push_back(s[15:8]);
    end
    driveFifo();
  endtask

  task automatic tick();
    @(negedge clk);
    if (rdPrev && fifoQ.size() > 0) void'(fifoQ.pop_front());
    rdPrev = fifoRd;
    if (fifoRd) rdCycles++;
    driveFifo();
    if (rstN) begin
      if (prevStrobeN && !txStrobeN)
        check(txReadyN == 1'b1, "R7 strobe fell with ready asserted", txReadyN, 1);
      if (!prevStrobeN && !txStrobeN)
        check(txData == prevData, "R7 data changed under strobe", txData, prevData);
      if (expectIdle)
        check(txStrobeN && !fifoRd, idleReq, {txStrobeN, fifoRd}, 2);
      check(accepted >= 4*int'(wordCount) && accepted <= 4*int'(wordCount) + 4,
            "R10 count versus bytes", int'(wordCount), accepted/4);
    end
    // receiver model
    if (!txStrobeN && txReadyN) begin
      if (rxLimit != 0) begin
        rxWait++;
        if (rxWait >= rxDelay) begin
          logic [7:0] exp;
          rxWait = 0;
          exp = (expQ.size() > 0) ? expQ.pop_front() : 8'h00;
          check(txData == exp, "R1 byte order", txData, exp);
          accepted++;
          if (rxLimit > 0) rxLimit--;
          txReadyN = 1'b0;
        end
      end
    end else if (txStrobeN && !txReadyN) begin
      rxWait++;
      if (rxWait >= rxDelay) begin
        rxWait = 0;
        txReadyN = 1'b1;
      end
    end
    prevStrobeN = txStrobeN;
    prevData    = txData;
  endtask

  task automatic runIdle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic waitQuiet();
    int quiet;
    quiet = 0;
    for (int i = 0; i < 4000 && quiet < 20; i++) begin
      tick();
      quiet = (!busy && txStrobeN) ? quiet + 1 : 0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    driveFifo();
    runIdle(3);
    // R8: reset state
    check(txStrobeN == 1'b1, "R8 strobe in reset", txStrobeN, 1);
    check(fifoRd == 1'b0, "R8 read in reset", fifoRd, 0);
    check(busy == 1'b0, "R8 busy in reset", busy, 0);
    check(wordCount == 16'd0, "R8 count in reset", wordCount, 0);
    rstN = 1'b1;

    // R2: below threshold nothing moves
    expectIdle = 1; idleReq = "R2 activity below threshold";
    pushSamples(HALF - 1);
    runIdle(100);
    expectIdle = 0;
    check(accepted == 0, "R2 bytes below threshold", accepted, 0);

    // R3: exactly one longword per threshold event
    pushSamples(1);
    waitQuiet();
    check(accepted == 4, "R3 bytes for one event", accepted, 4);
    check(wordCount == 16'd1, "R3 longwords for one event", wordCount, 1);
    check(fifoQ.size() == HALF - 2, "R3 buffer level after event", fifoQ.size(), HALF - 2);
    check(rdCycles == 2, "R9 reads per longword", rdCycles, 2);

    // R4: back to back while at or above threshold (16 -> 5 longwords)
    pushSamples(10);
    waitQuiet();
    check(wordCount == 16'd6, "R4 back-to-back longwords", wordCount, 6);
    check(accepted == 24, "R4 bytes back to back", accepted, 24);
    check(fifoQ.size() == HALF - 2, "R3 level after burst", fifoQ.size(), HALF - 2);
    check(rdCycles == 12, "R9 reads after burst", rdCycles, 12);
    check(expQ.size() == 2 * fifoQ.size(), "R1 stream alignment", expQ.size(), 2 * fifoQ.size());

    // R7: slow receiver
    rxDelay = 12;
    pushSamples(2);
    waitQuiet();
    check(wordCount == 16'd7, "R7 slow receiver longwords", wordCount, 7);
    check(accepted == 28, "R7 slow receiver bytes", accepted, 28);

    // R6: stall after the first byte while the threshold has dropped
    rxDelay = 2; rxLimit = 1;
    pushSamples(2);
    runIdle(300);
    check(txStrobeN == 1'b0, "R6 strobe held during stall", txStrobeN, 0);
    check(busy == 1'b1, "R10 busy during stall", busy, 1);
    check(accepted == 29, "R6 bytes during stall", accepted, 29);
    check(wordCount == 16'd7, "R10 count during stall", wordCount, 7);
    rxLimit = -1;
    waitQuiet();
    check(wordCount == 16'd8, "R6 longword completed", wordCount, 8);
    check(accepted == 32, "R6 all four bytes", accepted, 32);
    check(rdCycles == 16, "R9 reads total", rdCycles, 16);

    // R5: half-full forced against an empty buffer
    fifoQ.delete(); expQ.delete();
    forceHalf = 1; driveFifo();
    expectIdle = 1; idleReq = "R5 activity while empty";
    runIdle(100);
    expectIdle = 0; forceHalf = 0; driveFifo();
    check(wordCount == 16'd8, "R5 no longword while empty", wordCount, 8);

    // R8: reset in the middle of a longword
    rxLimit = 1;
    pushSamples(HALF);
    runIdle(60);
    check(busy == 1'b1, "R10 busy before reset", busy, 1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(txStrobeN == 1'b1, "R8 strobe on reset", txStrobeN, 1);
    check(fifoRd == 1'b0, "R8 read on reset", fifoRd, 0);
    check(busy == 1'b0, "R8 busy on reset", busy, 0);
    check(wordCount == 16'd0, "R8 count on reset", wordCount, 0);
    fifoQ.delete(); expQ.delete();
    txReadyN = 1'b1; rxWait = 0; rxLimit = -1; accepted = 0; rdCycles = 0;
    rdPrev = 0; prevStrobeN = 1; driveFifo();
    runIdle(4);
    rstN = 1'b1;
    expectIdle = 1; idleReq = "R8 activity after reset below threshold";
    pushSamples(HALF - 1);
    runIdle(50);
    expectIdle = 0;
    pushSamples(1);
    waitQuiet();
    check(wordCount == 16'd1, "R8 longwords after reset", wordCount, 1);
    check(accepted == 4, "R1 bytes after reset", accepted, 4);

    summary();
    $finish;
  end

endmodule